// File: doc/BRIEF.md
# Temperature Word Access Adapter

This block sits between a serial-bus command front end and a byte-wide register bank. It turns one 16-bit word read or write into two byte cycles on the bank's port. When the command targets the secondary temperature-sensor address, the two low command bits choose a fixed register pair: the reading, the configuration byte, the hysteresis limit or the over-temperature limit. Any other address reaches the single register named by the command byte.

The returned word is byte-swapped on purpose. The second register of a pair lands in the upper half and the first register lands in the lower half. A command is accepted on a strobe while the adapter is idle. The adapter then runs a lead byte cycle and a trail byte cycle back to back, and reports completion with a one-cycle pulse. Address matching, the serial physical layer and the register storage stay outside the block.

Top module: `tword_adapter`

## Requirements
- R1: After reset, busy, done, reg_we and reg_re are 0 and rd_word is 0x0000.
- R2: A command accepted at a clock edge (cmd_valid high, busy low) runs two consecutive byte cycles, lead then trail, with busy high. done is then high for exactly one cycle, and busy is low in that cycle.
- R3: With temp_sel high, cmd_code[1:0] picks the register pair, and bits [7:2] are ignored. Value 0 selects 0x50 then 0x51, 2 selects 0x53 then 0x54, and 3 selects 0x55 then 0x56. The lead cycle always uses the first address of the pair.
- R4: With temp_sel high and cmd_code[1:0] = 1, both byte cycles address 0x52. A read returns that byte in both halves of rd_word.
- R5: A paired read returns the trail (second) register in rd_word[15:8] and the lead (first) register in rd_word[7:0].
- R6: A paired write stores wr_word[15:8] into the first register during the lead cycle and wr_word[7:0] into the second register during the trail cycle.
- R7: A configuration write (temp_sel high, cmd_code[1:0] = 1) raises reg_we only in the trail cycle and stores wr_word[7:0] into 0x52. wr_word[15:8] is discarded.
- R8: With temp_sel low, both byte cycles address cmd_code. A read returns that byte in both halves, and a write stores wr_word[7:0] there with one strobe in the trail cycle.
- R9: While busy, cmd_valid and every other command input are ignored. The running access completes with the values latched when it was accepted, and no second access follows.
- R10: rd_word changes only in a cycle where done is high, and only after a read. A write leaves rd_word at its previous value.
- R11: reg_re is high in both byte cycles of a read and low otherwise. reg_we is never high outside a byte cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_we | input | 1 | 1 = word write, 0 = word read |
| temp_sel | input | 1 | Command targets the temperature-sensor address |
| cmd_code | input | 8 | Command byte |
| wr_word | input | 16 | Word to write |
| busy | output | 1 | Byte cycles in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_word | output | 16 | Byte-swapped read result, held until the next read |
| reg_addr | output | 8 | Register bank address |
| reg_wdata | output | 8 | Register bank write byte |
| reg_we | output | 1 | Register bank write strobe |
| reg_re | output | 1 | Register bank read strobe |
| reg_rdata | input | 8 | Register bank read byte, valid in the same cycle as reg_addr |

## Verification
The bench builds the adapter with its defaults: 8-bit address and command, 8-bit bytes, temperature window based at 0x50, and the swapped word order. At this size the bench can read through all 256 command bytes in both the temperature and the plain-address mode. It checks every byte-cycle address, strobe and returned word against a bench-held register image. It also writes through every pair selector with several data words, and injects a command mid-access to show that the inputs are latched.

// File: rtl/tw_pkg.sv
package tw_pkg;

   typedef enum logic [1:0] {
      TW_IDLE  = 2'd0,
      TW_LEAD  = 2'd1,
      TW_TRAIL = 2'd2
   } tw_phase_e;

   // register pair selectors carried in the low command bits
   localparam logic [1:0] SEL_READING = 2'd0;
   localparam logic [1:0] SEL_CONFIG  = 2'd1;
   localparam logic [1:0] SEL_HYST    = 2'd2;
   localparam logic [1:0] SEL_OVERT   = 2'd3;

endpackage

// File: rtl/tw_seq.sv
module tw_seq
   import tw_pkg::*;
#(
   parameter int CMD_W  = 8,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_we,
   input  logic              temp_sel,
   input  logic [CMD_W-1:0]  cmd_code,
   input  logic [WORD_W-1:0] wr_word,
   output tw_phase_e         phase,
   output logic              done,
   output logic [CMD_W-1:0]  cmd_q,
   output logic              we_q,
   output logic              temp_q,
   output logic [WORD_W-1:0] wdata_q
);

   tw_phase_e phase_q;
   logic      done_q;
   logic      accept;

   assign accept = cmd_valid && (phase_q == TW_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= TW_IDLE;
         done_q  <= 1'b0;
         cmd_q   <= '0;
         we_q    <= 1'b0;
         temp_q  <= 1'b0;
         wdata_q <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (phase_q)
            TW_IDLE: begin
               if (accept) begin
                  cmd_q   <= cmd_code;
                  we_q    <= cmd_we;
                  temp_q  <= temp_sel;
                  wdata_q <= wr_word;
                  phase_q <= TW_LEAD;
               end
            end
            TW_LEAD:  phase_q <= TW_TRAIL;
            TW_TRAIL: begin
               phase_q <= TW_IDLE;
               done_q  <= 1'b1;
            end
            default:  phase_q <= TW_IDLE;
         endcase
      end
   end

   assign phase = phase_q;
   assign done  = done_q;

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R2
   done_after_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> ($past(phase_q) == TW_TRAIL));

   // R2
   lead_to_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == TW_LEAD) |=> (phase_q == TW_TRAIL));

   // R9
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != TW_IDLE && $past(phase_q) != TW_IDLE)
         |-> ($stable(cmd_q) && $stable(wdata_q) && $stable(we_q)));

endmodule

// File: rtl/tw_decode.sv
module tw_decode
   import tw_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int TEMP_BASE = 'h50
) (
   input  logic              temp_sel,
   input  logic              is_write,
   input  logic [ADDR_W-1:0] cmd,
   output logic [ADDR_W-1:0] lead_addr,
   output logic [ADDR_W-1:0] trail_addr,
   output logic              lead_wr,
   output logic              trail_wr
);

   localparam logic [ADDR_W-1:0] A_RD_HI = ADDR_W'(TEMP_BASE);
   localparam logic [ADDR_W-1:0] A_RD_LO = ADDR_W'(TEMP_BASE + 1);
   localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(TEMP_BASE + 2);
   localparam logic [ADDR_W-1:0] A_HY_HI = ADDR_W'(TEMP_BASE + 3);
   localparam logic [ADDR_W-1:0] A_HY_LO = ADDR_W'(TEMP_BASE + 4);
   localparam logic [ADDR_W-1:0] A_OT_HI = ADDR_W'(TEMP_BASE + 5);
   localparam logic [ADDR_W-1:0] A_OT_LO = ADDR_W'(TEMP_BASE + 6);

   always_comb begin
      lead_addr  = cmd;
      trail_addr = cmd;
      lead_wr    = 1'b0;
      trail_wr   = is_write;
      if (temp_sel) begin
         unique case (cmd[1:0])
            SEL_READING: begin
               lead_addr  = A_RD_HI;
               trail_addr = A_RD_LO;
               lead_wr    = is_write;
            end
            SEL_CONFIG: begin
               lead_addr  = A_CFG;
               trail_addr = A_CFG;
            end
            SEL_HYST: begin
               lead_addr  = A_HY_HI;
               trail_addr = A_HY_LO;
               lead_wr    = is_write;
            end
            default: begin
               lead_addr  = A_OT_HI;
               trail_addr = A_OT_LO;
               lead_wr    = is_write;
            end
         endcase
      end
   end

endmodule

// File: rtl/tw_pack.sv
module tw_pack #(
   parameter int  BYTE_W    = 8,
   parameter bit  SWAP_WORD = 1'b1,
   localparam int WORD_W    = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_lead,
   input  logic              cap_trail,
   input  logic [BYTE_W-1:0] rdata,
   output logic [WORD_W-1:0] rd_word
);

   logic [BYTE_W-1:0] lead_q;
   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] joined;

   generate
      if (SWAP_WORD) begin : g_swap
         assign joined = {rdata, lead_q};
      end else begin : g_straight
         assign joined = {lead_q, rdata};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lead_q <= '0;
         word_q <= '0;
      end else begin
         if (cap_lead)  lead_q <= rdata;
         if (cap_trail) word_q <= joined;
      end
   end

   assign rd_word = word_q;

endmodule

// File: rtl/tword_adapter.sv
module tword_adapter
   import tw_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BYTE_W    = 8,
   parameter int TEMP_BASE = 'h50,
   parameter bit SWAP_WORD = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   input  logic                cmd_we,
   input  logic                temp_sel,
   input  logic [ADDR_W-1:0]   cmd_code,
   input  logic [2*BYTE_W-1:0] wr_word,
   output logic                busy,
   output logic                done,
   output logic [2*BYTE_W-1:0] rd_word,
   output logic [ADDR_W-1:0]   reg_addr,
   output logic [BYTE_W-1:0]   reg_wdata,
   output logic                reg_we,
   output logic                reg_re,
   input  logic [BYTE_W-1:0]   reg_rdata
);

   localparam int WORD_W = 2 * BYTE_W;

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("tword_adapter: ADDR_W too small for the register pair map");
      end
      if (BYTE_W < 1) begin : g_bad_byte
         $error("tword_adapter: BYTE_W must be positive");
      end
      if (TEMP_BASE < 0 || TEMP_BASE + 6 >= (1 << ADDR_W)) begin : g_bad_base
         $error("tword_adapter: temperature window exceeds address space");
      end
   endgenerate

   tw_phase_e          phase;
   logic [ADDR_W-1:0]  cmd_q;
   logic               we_q;
   logic               temp_q;
   logic [WORD_W-1:0]  wdata_q;
   logic [ADDR_W-1:0]  lead_addr;
   logic [ADDR_W-1:0]  trail_addr;
   logic               lead_wr;
   logic               trail_wr;
   logic               in_lead;
   logic               in_trail;

   tw_seq #(.CMD_W(ADDR_W), .WORD_W(WORD_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_we    (cmd_we),
      .temp_sel  (temp_sel),
      .cmd_code  (cmd_code),
      .wr_word   (wr_word),
      .phase     (phase),
      .done      (done),
      .cmd_q     (cmd_q),
      .we_q      (we_q),
      .temp_q    (temp_q),
      .wdata_q   (wdata_q)
   );

   tw_decode #(.ADDR_W(ADDR_W), .TEMP_BASE(TEMP_BASE)) u_dec (
      .temp_sel   (temp_q),
      .is_write   (we_q),
      .cmd        (cmd_q),
      .lead_addr  (lead_addr),
      .trail_addr (trail_addr),
      .lead_wr    (lead_wr),
      .trail_wr   (trail_wr)
   );

   assign in_lead  = (phase == TW_LEAD);
   assign in_trail = (phase == TW_TRAIL);
   assign busy     = in_lead || in_trail;

   assign reg_addr  = in_lead ? lead_addr : trail_addr;
   assign reg_wdata = in_lead ? wdata_q[WORD_W-1:BYTE_W] : wdata_q[BYTE_W-1:0];
   assign reg_we    = (in_lead && lead_wr) || (in_trail && trail_wr);
   assign reg_re    = busy && !we_q;

   tw_pack #(.BYTE_W(BYTE_W), .SWAP_WORD(SWAP_WORD)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_lead  (in_lead && !we_q),
      .cap_trail (in_trail && !we_q),
      .rdata     (reg_rdata),
      .rd_word   (rd_word)
   );

   // R10
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_word) |-> done);

   // R11
   we_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> busy);

   // R6
   pair_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && in_lead) |=> (reg_we && reg_addr == $past(reg_addr) + 1'b1));

   // R2
   idle_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

// File: tb/sim_tword_adapter.sv
module sim_tword_adapter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_we = 1'b0;
   logic        temp_sel = 1'b0;
   logic [7:0]  cmd_code = '0;
   logic [15:0] wr_word = '0;
   logic        busy, done, reg_we, reg_re;
   logic [15:0] rd_word;
   logic [7:0]  reg_addr, reg_wdata, reg_rdata;

   logic [7:0]  mem [256];
   logic        fill_req = 1'b0;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   // sampled per access
   logic [7:0]  s_a0, s_a1;
   logic        s_we0, s_we1, s_re0, s_re1, s_b0, s_b1, s_d1;
   logic        s_done, s_busy2, s_done3, s_busy3;
   logic [15:0] s_rd;

   always #10 clk = ~clk;

   tword_adapter u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_we    (cmd_we),
      .temp_sel  (temp_sel),
      .cmd_code  (cmd_code),
      .wr_word   (wr_word),
      .busy      (busy),
      .done      (done),
      .rd_word   (rd_word),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_re    (reg_re),
      .reg_rdata (reg_rdata)
   );

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 37 + 11) ^ (i >> 3));
   endfunction

   always @(posedge clk) begin
      if (fill_req) begin
         for (int i = 0; i < 256; i++) mem[i] <= pat(i);
      end else if (reg_we) begin
         mem[reg_addr] <= reg_wdata;
      end
   end

   assign reg_rdata = mem[reg_addr];

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic fill;
      @(negedge clk); fill_req = 1'b1;
      @(negedge clk); fill_req = 1'b0;
   endtask

   task automatic pair_of(input bit t, input logic [7:0] c, output logic [7:0] a0, output logic [7:0] a1);
      if (!t) begin a0 = c; a1 = c; end
      else begin
         case (c[1:0])
            2'd0: begin a0 = 8'h50; a1 = 8'h51; end
            2'd1: begin a0 = 8'h52; a1 = 8'h52; end
            2'd2: begin a0 = 8'h53; a1 = 8'h54; end
            default: begin a0 = 8'h55; a1 = 8'h56; end
         endcase
      end
   endtask

   task automatic access(input bit t, input bit w, input logic [7:0] c, input logic [15:0] d, input bit intrude);
      @(negedge clk);
      temp_sel = t; cmd_we = w; cmd_code = c; wr_word = d; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      s_a0 = reg_addr; s_we0 = reg_we; s_re0 = reg_re; s_b0 = busy;
      if (intrude) begin
         cmd_valid = 1'b1; cmd_we = 1'b1; temp_sel = 1'b1;
         cmd_code = 8'h03; wr_word = 16'hDEAD;
      end
      @(negedge clk);
      cmd_valid = 1'b0;
      s_a1 = reg_addr; s_we1 = reg_we; s_re1 = reg_re; s_b1 = busy; s_d1 = done;
      @(negedge clk);
      s_done = done; s_rd = rd_word; s_busy2 = busy;
      @(negedge clk);
      s_done3 = done; s_busy3 = busy;
   endtask

   task automatic check_frame(input bit t, input bit w, input logic [7:0] c);
      logic [7:0] a0, a1;
      pair_of(t, c, a0, a1);
      check(s_b0 && s_b1 && !s_d1, "R2 busy over both byte cycles", {s_b0, s_b1, s_d1}, 3'b110);
      check(s_done && !s_busy2 && !s_done3 && !s_busy3, "R2 single done pulse",
            {s_done, s_busy2, s_done3, s_busy3}, 4'b1000);
      check(s_a0 == a0, t ? "R3 lead address" : "R8 lead address", s_a0, a0);
      check(s_a1 == a1, t ? "R3 trail address" : "R8 trail address", s_a1, a1);
      check(s_re0 == !w && s_re1 == !w, "R11 read strobe", {s_re0, s_re1}, {!w, !w});
   endtask

   initial begin
      logic [7:0]  a0, a1;
      logic [15:0] exp, last;
      repeat (3) @(negedge clk);
      // R1
      check(!busy && !done && !reg_we && !reg_re && rd_word == 16'h0,
            "R1 reset state", {busy, done, reg_we, reg_re, rd_word}, 20'h0);
      rst_n = 1'b1;
      fill();

      // read sweep, temperature mode: R3 R4 R5
      for (int c = 0; c < 256; c++) begin
         access(1'b1, 1'b0, 8'(c), 16'h0, 1'b0);
         check_frame(1'b1, 1'b0, 8'(c));
         pair_of(1'b1, 8'(c), a0, a1);
         exp = {pat(a1), pat(a0)};
         check(s_rd == exp, (c % 4 == 1) ? "R4 config duplicated" : "R5 swapped pair read", s_rd, exp);
      end

      // read sweep, plain address: R8
      for (int c = 0; c < 256; c++) begin
         access(1'b0, 1'b0, 8'(c), 16'h0, 1'b0);
         check_frame(1'b0, 1'b0, 8'(c));
         exp = {pat(c), pat(c)};
         check(s_rd == exp, "R8 duplicated byte read", s_rd, exp);
      end
      last = s_rd;

      // paired and config writes: R6 R7 R10
      for (int k = 0; k < 4; k++) begin
         for (int s = 0; s < 4; s++) begin
            logic [7:0]  c;
            logic [15:0] d;
            c = 8'((k << 2) | s) ^ 8'(k * 64);
            c[1:0] = 2'(s);
            d = 16'(16'h1357 * (k + 1) + s * 16'h0F0F);
            fill();
            access(1'b1, 1'b1, c, d, 1'b0);
            check_frame(1'b1, 1'b1, c);
            pair_of(1'b1, c, a0, a1);
            check(s_rd == last, "R10 write leaves rd_word", s_rd, last);
            if (s == 1) begin
               check(!s_we0 && s_we1, "R7 single trail strobe", {s_we0, s_we1}, 2'b01);
               check(mem[8'h52] == d[7:0], "R7 config low byte", mem[8'h52], d[7:0]);
               check(mem[8'h51] == pat(8'h51) && mem[8'h53] == pat(8'h53),
                     "R7 neighbours untouched", {mem[8'h51], mem[8'h53]}, {pat(8'h51), pat(8'h53)});
            end else begin
               check(s_we0 && s_we1, "R6 two strobes", {s_we0, s_we1}, 2'b11);
               check(mem[a0] == d[15:8], "R6 high byte to first", mem[a0], d[15:8]);
               check(mem[a1] == d[7:0], "R6 low byte to second", mem[a1], d[7:0]);
            end
         end
      end

      // plain address writes: R8
      for (int c = 0; c < 256; c += 17) begin
         fill();
         access(1'b0, 1'b1, 8'(c), 16'hA5C3 ^ 16'(c), 1'b0);
         check_frame(1'b0, 1'b1, 8'(c));
         exp = 16'hA5C3 ^ 16'(c);
         check(!s_we0 && s_we1, "R8 single write strobe", {s_we0, s_we1}, 2'b01);
         check(mem[c] == exp[7:0], "R8 low byte stored", mem[c], exp[7:0]);
      end

      // command while busy: R9
      fill();
      access(1'b1, 1'b0, 8'h00, 16'h0, 1'b1);
      check_frame(1'b1, 1'b0, 8'h00);
      exp = {pat(8'h51), pat(8'h50)};
      check(s_rd == exp, "R9 running read unaffected", s_rd, exp);
      check(mem[8'h55] == pat(8'h55) && mem[8'h56] == pat(8'h56), "R9 intruding write ignored",
            {mem[8'h55], mem[8'h56]}, {pat(8'h55), pat(8'h56)});
      fill();
      access(1'b1, 1'b1, 8'h02, 16'h4321, 1'b1);
      check(mem[8'h53] == 8'h43 && mem[8'h54] == 8'h21, "R9 latched write data",
            {mem[8'h53], mem[8'h54]}, 16'h4321);

      if (!ended) begin
         ended = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(20 * 150000);
      if (!ended) begin
         ended = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=hung expected=complete");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule